// File: doc/BRIEF.md
# DMA Channel Context Autoinitialization Controller

This block is the control state machine for a single DMA logical channel that feeds a display. Software writes a programming context and a set of control bits. The controller copies the programming context into an active context, which the transfer engine then uses. The transfer engine appears here only as handshakes. It grants the channel with `xfer_grant`, the controller opens a transfer with `xfer_start`, and the engine reports the end with `xfer_done`.

Each completed transfer leads to one of four outcomes, set by the auto-init, repeat and end-of-programming bits:
- go idle;
- wait in a pending state;
- re-arm with the same active context;
- load the programming context afresh.

A transfer stops at once in three cases:
- software clears the enable bit;
- the destination reports an underflow;
- a second hardware request arrives while one is being serviced.

Underflow and dropped requests are recorded in sticky status bits. Each sticky bit drives a level interrupt.

States and their 3-bit codes on `chan_state`:
- IDLE (0): the channel is off.
- LOAD (1): waiting for a grant so the context can be copied.
- ARM (2): the context is loaded and the controller waits for a request.
- RUN (3): a transfer is in progress.
- PEND (4): auto-init is on, but neither repeat nor end-of-programming is set.

Transitions:
- IDLE→LOAD on enable.
- LOAD→ARM on grant.
- ARM→RUN on a request while the display side is enabled.
- RUN→IDLE, LOAD, ARM or PEND at the end of a transfer.
- RUN→IDLE on disable, underflow or an overlapping request.
- PEND→LOAD on end-of-programming, which takes priority.
- PEND→ARM on repeat.
- Any state goes to IDLE on disable.

Top module: `dma_ctx_ctrl`

## Requirements
- R1: After reset `chan_state` is 0 (IDLE), `en_bit` is 0, `active_ctx` is 0, both interrupts are low and `xfer_start` is low.
- R2: A control write with enable set moves IDLE to LOAD (1) at that edge. In LOAD, the first cycle with `xfer_grant` high copies the programming context into `active_ctx` and moves to ARM (2).
- R3: In ARM, `xfer_start` is high for the cycle in which `hw_req` and `disp_en` are both high, and the state becomes RUN (3) at that edge. A request without `disp_en`, or `disp_en` without a request, leaves the state at ARM and keeps `xfer_start` low.
- R4: A transfer that ends with auto-init clear goes to IDLE and clears `en_bit`.
- R5: A transfer that ends with auto-init and end-of-programming set goes to LOAD whatever the repeat bit is. At the next grant it loads the new programming context.
- R6: A transfer that ends with auto-init and repeat set and end-of-programming clear returns to ARM with `active_ctx` unchanged.
- R7: A transfer that ends with auto-init set and repeat and end-of-programming both clear enters PEND (4). PEND leaves for LOAD once end-of-programming is set, even when repeat is also set, and for ARM once only repeat is set. Either way it leaves one cycle after the write.
- R8: The end-of-programming bit clears itself when the context copy happens.
- R9: A control write with enable clear sends every state to IDLE at the edge of the write. A transfer in RUN ends there: `xfer_busy` is low the next cycle. This takes priority over underflow, overlap and end of transfer.
- R10: An underflow in RUN pulses `uf_to_disp` in that cycle. At that edge the controller clears `en_bit`, goes to IDLE and sets the underflow status.
- R11: A `hw_req` in RUN, without underflow, sets the event-drop status, clears `en_bit` and goes to IDLE.
- R12: The status bits are sticky, and each drives its level interrupt. Writing 1 to `stat_clr` bit 0 clears underflow, and writing 1 to bit 1 clears event-drop. Writing to the other bit leaves a status unchanged.
- R13: A control or programming write in the same cycle as a context copy acts after the copy. The copy uses the old programming context, and the written end-of-programming value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Written enable bit |
| ctl_autoinit | input | 1 | Written auto-init bit |
| ctl_repeat | input | 1 | Written repeat bit |
| ctl_endprog | input | 1 | Written end-of-programming bit |
| prog_we | input | 1 | Programming context write strobe |
| prog_wdata | input | CTX_W | Programming context value |
| stat_clr | input | 2 | Write-1-to-clear status (bit 0 underflow, bit 1 drop) |
| disp_en | input | 1 | Display side enable |
| hw_req | input | 1 | Hardware request |
| xfer_grant | input | 1 | Physical channel grant |
| xfer_done | input | 1 | End of current transfer |
| dst_underflow | input | 1 | Destination underflow |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_busy | output | 1 | Transfer in progress (RUN) |
| active_ctx | output | CTX_W | Active context |
| chan_state | output | 3 | State code |
| en_bit | output | 1 | Enable bit |
| endprog_bit | output | 1 | End-of-programming bit |
| uf_to_disp | output | 1 | Underflow indication to the display controller |
| irq_underflow | output | 1 | Underflow interrupt (level) |
| irq_drop | output | 1 | Event-drop interrupt (level) |

## Verification
A wrong state shows on `chan_state` one edge after the event that caused it, because every transition is exposed there. A stale or early context copy shows on `active_ctx` at the grant edge. A missed self-clear of end-of-programming shows as a second copy at the next transfer end. A wrong abort priority appears within one cycle, either as a stray sticky interrupt or as `en_bit` left high.

// File: rtl/dma_ctx_pkg.sv
package dma_ctx_pkg;

    typedef enum logic [2:0] {
        CS_IDLE = 3'd0,
        CS_LOAD = 3'd1,
        CS_ARM  = 3'd2,
        CS_RUN  = 3'd3,
        CS_PEND = 3'd4
    } ctx_state_e;

    localparam int ST_UF   = 0;
    localparam int ST_DROP = 1;
    localparam int N_STAT  = 2;

endpackage

// File: rtl/dma_ctx_regs.sv
module dma_ctx_regs #(
    parameter int CTX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_ai,
    input  logic             ctl_rep,
    input  logic             ctl_ep,
    input  logic             prog_we,
    input  logic [CTX_W-1:0] prog_wdata,
    input  logic             copy_ctx,
    input  logic             kill_en,
    output logic             en_q,
    output logic             en_eff,
    output logic             ai_q,
    output logic             rep_q,
    output logic             ep_q,
    output logic [CTX_W-1:0] active_q
);

    logic [CTX_W-1:0] prog_q;

    // a software write is decoded in its own cycle so a disable acts at once
    assign en_eff = ctl_we ? ctl_en : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ai_q     <= 1'b0;
            rep_q    <= 1'b0;
            ep_q     <= 1'b0;
            prog_q   <= '0;
            active_q <= '0;
        end else begin
            // software writes land after any hardware update of the same cycle
            if (ctl_we) begin
                en_q  <= ctl_en;
                ai_q  <= ctl_ai;
                rep_q <= ctl_rep;
                ep_q  <= ctl_ep;
            end else begin
                if (kill_en)  en_q <= 1'b0;
                if (copy_ctx) ep_q <= 1'b0;
            end
            if (prog_we)  prog_q   <= prog_wdata;
            if (copy_ctx) active_q <= prog_q;
        end
    end

    // R8
    ep_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_ctx && !ctl_we) |=> !ep_q);

endmodule

// File: rtl/dma_ctx_status.sv
module dma_ctx_status #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] flag_q
);

    for (genvar i = 0; i < NB; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (clr_i[i])
                flag_q[i] <= 1'b0;
        end

        // R12
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    end

endmodule

// File: rtl/dma_ctx_fsm.sv
module dma_ctx_fsm
    import dma_ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_eff,
    input  logic       ai,
    input  logic       rep,
    input  logic       ep,
    input  logic       disp_en,
    input  logic       hw_req,
    input  logic       grant,
    input  logic       done,
    input  logic       underflow,
    output ctx_state_e state,
    output logic       copy_ctx,
    output logic       kill_en,
    output logic       xfer_start,
    output logic       xfer_busy,
    output logic       uf_evt,
    output logic       drop_evt
);

    ctx_state_e nxt;
    logic       run_ok;
    logic       end_evt;

    always_comb begin
        run_ok  = (state == CS_RUN) && en_eff;
        end_evt = run_ok && !underflow && !hw_req && done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE: if (en_eff) nxt = CS_LOAD;
            CS_LOAD: begin
                if (!en_eff)    nxt = CS_IDLE;
                else if (grant) nxt = CS_ARM;
            end
            CS_ARM: begin
                if (!en_eff)                nxt = CS_IDLE;
                else if (hw_req && disp_en) nxt = CS_RUN;
            end
            CS_RUN: begin
                if (!en_eff || underflow || hw_req) nxt = CS_IDLE;
                else if (done) begin
                    if (!ai)     nxt = CS_IDLE;
                    else if (ep) nxt = CS_LOAD;
                    else if (rep) nxt = CS_ARM;
                    else         nxt = CS_PEND;
                end
            end
            CS_PEND: begin
                if (!en_eff)  nxt = CS_IDLE;
                else if (ep)  nxt = CS_LOAD;
                else if (rep) nxt = CS_ARM;
            end
            default: nxt = CS_IDLE;
        endcase
    end

    always_comb begin
        uf_evt     = run_ok && underflow;
        drop_evt   = run_ok && !underflow && hw_req;
        kill_en    = uf_evt || drop_evt || (end_evt && !ai);
        copy_ctx   = (state == CS_LOAD) && en_eff && grant;
        xfer_start = (state == CS_ARM) && en_eff && hw_req && disp_en;
        xfer_busy  = (state == CS_RUN);
    end

    // R3
    start_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (state == CS_RUN));

    // R9
    sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != CS_IDLE) && !en_eff) |=> (state == CS_IDLE));

    // R10
    uf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_RUN) && en_eff && underflow) |=> (state == CS_IDLE));

    // R11
    drop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_RUN) && en_eff && !underflow && hw_req) |=> (state == CS_IDLE));

endmodule

// File: rtl/dma_ctx_ctrl.sv
module dma_ctx_ctrl
    import dma_ctx_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_autoinit,
    input  logic             ctl_repeat,
    input  logic             ctl_endprog,
    input  logic             prog_we,
    input  logic [CTX_W-1:0] prog_wdata,
    input  logic [1:0]       stat_clr,
    input  logic             disp_en,
    input  logic             hw_req,
    input  logic             xfer_grant,
    input  logic             xfer_done,
    input  logic             dst_underflow,
    output logic             xfer_start,
    output logic             xfer_busy,
    output logic [CTX_W-1:0] active_ctx,
    output logic [2:0]       chan_state,
    output logic             en_bit,
    output logic             endprog_bit,
    output logic             uf_to_disp,
    output logic             irq_underflow,
    output logic             irq_drop
);

    logic              en_eff, ai_q, rep_q, ep_q;
    logic              copy_ctx, kill_en, uf_evt, drop_evt;
    ctx_state_e        state;
    logic [N_STAT-1:0] st_set, st_q;

    dma_ctx_regs #(.CTX_W(CTX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_en     (ctl_en),
        .ctl_ai     (ctl_autoinit),
        .ctl_rep    (ctl_repeat),
        .ctl_ep     (ctl_endprog),
        .prog_we    (prog_we),
        .prog_wdata (prog_wdata),
        .copy_ctx   (copy_ctx),
        .kill_en    (kill_en),
        .en_q       (en_bit),
        .en_eff     (en_eff),
        .ai_q       (ai_q),
        .rep_q      (rep_q),
        .ep_q       (ep_q),
        .active_q   (active_ctx)
    );

    dma_ctx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_eff     (en_eff),
        .ai         (ai_q),
        .rep        (rep_q),
        .ep         (ep_q),
        .disp_en    (disp_en),
        .hw_req     (hw_req),
        .grant      (xfer_grant),
        .done       (xfer_done),
        .underflow  (dst_underflow),
        .state      (state),
        .copy_ctx   (copy_ctx),
        .kill_en    (kill_en),
        .xfer_start (xfer_start),
        .xfer_busy  (xfer_busy),
        .uf_evt     (uf_evt),
        .drop_evt   (drop_evt)
    );

    always_comb begin
        st_set          = '0;
        st_set[ST_UF]   = uf_evt;
        st_set[ST_DROP] = drop_evt;
    end

    dma_ctx_status #(.NB(N_STAT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (stat_clr),
        .flag_q (st_q)
    );

    assign chan_state    = state;
    assign endprog_bit   = ep_q;
    assign uf_to_disp    = uf_evt;
    assign irq_underflow = st_q[ST_UF];
    assign irq_drop      = st_q[ST_DROP];

    // R2
    copy_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_ctx != $past(active_ctx)) |-> $past((state == CS_LOAD) && xfer_grant));

    // R6
    repeat_keeps_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_RUN) && en_bit && !ctl_we && !dst_underflow && !hw_req &&
         xfer_done && ai_q && rep_q && !ep_q)
        |=> ((state == CS_ARM) && $stable(active_ctx)));

    // R10
    uf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_to_disp |=> irq_underflow);

endmodule

// File: tb/dma_ctx_ctrl_bench.sv
`timescale 1ns/1ps
module dma_ctx_ctrl_bench;

    localparam int CTX_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0, ctl_en = 1'b0, ctl_autoinit = 1'b0;
    logic             ctl_repeat = 1'b0, ctl_endprog = 1'b0;
    logic             prog_we = 1'b0;
    logic [CTX_W-1:0] prog_wdata = '0;
    logic [1:0]       stat_clr = 2'b00;
    logic             disp_en = 1'b0, hw_req = 1'b0, xfer_grant = 1'b0;
    logic             xfer_done = 1'b0, dst_underflow = 1'b0;
    logic             xfer_start, xfer_busy, en_bit, endprog_bit;
    logic             uf_to_disp, irq_underflow, irq_drop;
    logic [CTX_W-1:0] active_ctx;
    logic [2:0]       chan_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_ctx_ctrl #(.CTX_W(CTX_W)) u_dma_ctx_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
        .ctl_autoinit(ctl_autoinit), .ctl_repeat(ctl_repeat), .ctl_endprog(ctl_endprog),
        .prog_we(prog_we), .prog_wdata(prog_wdata), .stat_clr(stat_clr),
        .disp_en(disp_en), .hw_req(hw_req), .xfer_grant(xfer_grant),
        .xfer_done(xfer_done), .dst_underflow(dst_underflow),
        .xfer_start(xfer_start), .xfer_busy(xfer_busy), .active_ctx(active_ctx),
        .chan_state(chan_state), .en_bit(en_bit), .endprog_bit(endprog_bit),
        .uf_to_disp(uf_to_disp), .irq_underflow(irq_underflow), .irq_drop(irq_drop)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wctl(input logic en, input logic ai, input logic rep, input logic ep);
        ctl_we = 1'b1; ctl_en = en; ctl_autoinit = ai; ctl_repeat = rep; ctl_endprog = ep;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic wprog(input logic [CTX_W-1:0] v);
        prog_we = 1'b1; prog_wdata = v;
        tick();
        prog_we = 1'b0;
    endtask

    task automatic grant();
        xfer_grant = 1'b1;
        tick();
        xfer_grant = 1'b0;
    endtask

    task automatic start_xfer(input string tag);
        hw_req = 1'b1; disp_en = 1'b1;
        #0;
        chk({tag, " xfer_start"}, 32'(xfer_start), 32'd1);
        tick();
        hw_req = 1'b0;
        chk({tag, " run"}, 32'(chan_state), 32'd3);
    endtask

    task automatic end_xfer();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 state", 32'(chan_state), 32'd0);
        chk("R1 en", 32'(en_bit), 32'd0);
        chk("R1 active", 32'(active_ctx), 32'd0);
        chk("R1 irq", {30'd0, irq_drop, irq_underflow}, 32'd0);
        chk("R1 start", 32'(xfer_start), 32'd0);

        // sweep of every auto-init / repeat / end-of-programming combination
        for (int c = 0; c < 8; c++) begin
            logic ai, rep, ep;
            logic [CTX_W-1:0] va, vb;
            ai = c[2]; rep = c[1]; ep = c[0];
            va = CTX_W'(16'h1000 + c);
            vb = CTX_W'(16'h2000 + c);
            wprog(va);
            wctl(1'b1, ai, rep, 1'b0);
            chk("R2 load", 32'(chan_state), 32'd1);
            grant();
            chk("R2 arm", 32'(chan_state), 32'd2);
            chk("R2 copy", 32'(active_ctx), 32'(va));
            wprog(vb);
            wctl(1'b1, ai, rep, ep);
            start_xfer("R3");
            end_xfer();
            if (!ai) begin
                chk("R4 idle", 32'(chan_state), 32'd0);
                chk("R4 en", 32'(en_bit), 32'd0);
            end else if (ep) begin
                chk("R5 load", 32'(chan_state), 32'd1);
                chk("R5 old ctx", 32'(active_ctx), 32'(va));
                grant();
                chk("R5 new ctx", 32'(active_ctx), 32'(vb));
                chk("R5 arm", 32'(chan_state), 32'd2);
                chk("R8 ep clear", 32'(endprog_bit), 32'd0);
            end else if (rep) begin
                chk("R6 arm", 32'(chan_state), 32'd2);
                chk("R6 ctx kept", 32'(active_ctx), 32'(va));
            end else begin
                chk("R7 pend", 32'(chan_state), 32'd4);
                wctl(1'b1, 1'b1, 1'b1, 1'b0);
                chk("R7 pend hold", 32'(chan_state), 32'd4);
                tick();
                chk("R7 resume arm", 32'(chan_state), 32'd2);
                chk("R7 ctx kept", 32'(active_ctx), 32'(va));
            end
            wctl(1'b0, 1'b0, 1'b0, 1'b0);
            chk("R9 stop", 32'(chan_state), 32'd0);
        end

        // R7: pending channel resumed by end-of-programming (wins over repeat)
        wprog(16'h0005);
        wctl(1'b1, 1'b1, 1'b0, 1'b0);
        grant();
        start_xfer("R7");
        end_xfer();
        chk("R7 pend2", 32'(chan_state), 32'd4);
        wprog(16'h0006);
        wctl(1'b1, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R7 resume load", 32'(chan_state), 32'd1);
        grant();
        chk("R7 new ctx", 32'(active_ctx), 32'h6);
        wctl(1'b0, 1'b0, 1'b0, 1'b0);

        // R3: gating by display enable and request
        wctl(1'b1, 1'b1, 1'b1, 1'b0);
        grant();
        disp_en = 1'b0; hw_req = 1'b1;
        #0;
        chk("R3 no disp", 32'(xfer_start), 32'd0);
        tick();
        chk("R3 hold arm", 32'(chan_state), 32'd2);
        hw_req = 1'b0; disp_en = 1'b1;
        #0;
        chk("R3 no req", 32'(xfer_start), 32'd0);
        tick();
        chk("R3 hold arm2", 32'(chan_state), 32'd2);
        start_xfer("R3b");
        // R9: disable during a transfer
        wctl(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R9 abort idle", 32'(chan_state), 32'd0);
        chk("R9 busy", 32'(xfer_busy), 32'd0);
        chk("R9 en", 32'(en_bit), 32'd0);

        // R10: underflow
        wctl(1'b1, 1'b1, 1'b1, 1'b0);
        grant();
        start_xfer("R10");
        dst_underflow = 1'b1;
        #0;
        chk("R10 uf pulse", 32'(uf_to_disp), 32'd1);
        tick();
        dst_underflow = 1'b0;
        chk("R10 idle", 32'(chan_state), 32'd0);
        chk("R10 en", 32'(en_bit), 32'd0);
        chk("R10 irq", 32'(irq_underflow), 32'd1);
        chk("R10 no drop", 32'(irq_drop), 32'd0);
        tick();
        chk("R12 sticky", 32'(irq_underflow), 32'd1);
        stat_clr = 2'b10;
        tick();
        chk("R12 other bit", 32'(irq_underflow), 32'd1);
        stat_clr = 2'b01;
        tick();
        stat_clr = 2'b00;
        chk("R12 uf clear", 32'(irq_underflow), 32'd0);

        // R11: overlapping request
        wctl(1'b1, 1'b1, 1'b1, 1'b0);
        grant();
        start_xfer("R11");
        hw_req = 1'b1;
        tick();
        hw_req = 1'b0;
        chk("R11 idle", 32'(chan_state), 32'd0);
        chk("R11 en", 32'(en_bit), 32'd0);
        chk("R11 irq", 32'(irq_drop), 32'd1);
        chk("R11 no uf", 32'(irq_underflow), 32'd0);
        stat_clr = 2'b10;
        tick();
        stat_clr = 2'b00;
        chk("R12 drop clear", 32'(irq_drop), 32'd0);

        // R9: disable outranks a simultaneous underflow
        wctl(1'b1, 1'b1, 1'b1, 1'b0);
        grant();
        start_xfer("R9b");
        ctl_we = 1'b1; ctl_en = 1'b0; dst_underflow = 1'b1;
        #0;
        chk("R9 no uf pulse", 32'(uf_to_disp), 32'd0);
        tick();
        ctl_we = 1'b0; dst_underflow = 1'b0;
        chk("R9 prio idle", 32'(chan_state), 32'd0);
        chk("R9 prio no irq", 32'(irq_underflow), 32'd0);

        // R13: writes in the copy cycle act after the copy
        wprog(16'hAAAA);
        wctl(1'b1, 1'b1, 1'b0, 1'b0);
        xfer_grant = 1'b1;
        prog_we = 1'b1; prog_wdata = 16'hBBBB;
        ctl_we = 1'b1; ctl_en = 1'b1; ctl_autoinit = 1'b1; ctl_repeat = 1'b0; ctl_endprog = 1'b1;
        tick();
        xfer_grant = 1'b0; prog_we = 1'b0; ctl_we = 1'b0;
        chk("R13 old ctx", 32'(active_ctx), 32'hAAAA);
        chk("R13 ep kept", 32'(endprog_bit), 32'd1);
        chk("R13 arm", 32'(chan_state), 32'd2);
        start_xfer("R13");
        end_xfer();
        chk("R13 load", 32'(chan_state), 32'd1);
        grant();
        chk("R13 new ctx", 32'(active_ctx), 32'hBBBB);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule